// File: doc/BRIEF.md
# DMA Channel Command and Status Register Unit

This unit holds the software-visible control state for a set of DMA channels. Each channel has three registers on a simple 32-bit word bus. The command register is write-only. Each of its bits fires a one-cycle action pulse toward the data-movement engine or clears one status flag. The control register holds a few plain mode fields and eight interrupt enables. Each enable is changed through its own set bit and its own clear bit, so software never reads the register before changing one enable. The status register reports sticky event flags, two live ready levels, a busy indication and the channel's combined interrupt request.

The data-movement engine sits outside this unit. It receives the start, continue, stop, abort, FIFO-reset and channel-reset strobes and the mode fields. It sends back one-cycle event pulses and two level signals. A single interrupt output is the OR of all channel requests.

The word address is {channel, register}. Register 0 is command, 1 is control, 2 is status and 3 reads as zero. Read data is registered and appears with `bus_rvalid` one cycle after `bus_rd`.

Top module: `dma_chan_csr`

## Requirements
- R1: After the synchronous reset, every channel's enables, mode fields, sticky flags, link-pause state and busy bit are zero, all strobes are low and `irq` is low.
- R2: A command-register write fires a strobe on the matching output in the cycle after the write, for one cycle only. The command bits are start (bit 0), continue (bit 1), stop (bit 2), abort (bit 3), FIFO reset (bit 4) and channel reset (bit 31). Command-register reads return zero.
- R3: Enable k (0 ring-buffer, 1 link-complete, 2 device-ready, 3 memory-ready, 4 done, 5 SAR, 6 link-pause, 7 global) is set by control bit 17+2k and cleared by control bit 16+2k. Writing 1 to both bits, or 0 to both, leaves the enable unchanged. The enable reads back at bit 17+2k, and the even positions read 0.
- R4: Every control write loads continue mode (bit 0), ring mode (bit 1), burst enable (bit 14) and FIFO disable (bit 15). These drive the matching outputs and read back in place.
- R5: The sticky status flags are ring-buffer (bit 17), link-complete (bit 19), done (bit 25), SAR (bit 27) and error (bit 15). An event pulse sets each flag. Ring-buffer, link-complete and done are cleared only by command bits 6, 5 and 7. SAR and error are cleared only by channel reset. Reading status clears nothing.
- R6: When an event pulse and the clear command for the same flag fall in the same cycle, the flag ends up set.
- R7: Status bit 29 (link pause) is set by command bit 9 or by a link-pause event, and cleared by command bit 8. A write that holds both command bits leaves it unchanged.
- R8: Status bit 0 (busy) is set by start and cleared by a done event or by abort. Abort wins over start in the same write.
- R9: Command bit 31 clears busy, link pause and all sticky flags, even against an event in the same cycle. Enables and mode fields keep their values.
- R10: Status bit 31 is set when the global enable is on and at least one source in bits 17..29 is set with its own enable on. `irq` is the OR of these bits over all channels, registered one cycle later.
- R11: A write reaches only the addressed channel. Register 3 reads as zero. `bus_rvalid` follows `bus_rd` by one cycle.
- R12: Device-ready (bit 21) and memory-ready (bit 23) follow the level inputs and are not sticky.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Word address {channel, register} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| dp_start | output | 4 | Start strobe per channel |
| dp_continue | output | 4 | Continue strobe per channel |
| dp_stop | output | 4 | Stop strobe per channel |
| dp_abort | output | 4 | Abort strobe per channel |
| dp_fifo_rst | output | 4 | FIFO reset strobe per channel |
| dp_chan_rst | output | 4 | Channel reset strobe per channel |
| dp_cont_mode | output | 4 | Continue mode field per channel |
| dp_ring_mode | output | 4 | Ring-buffer mode field per channel |
| dp_burst_en | output | 4 | Burst enable field per channel |
| dp_fifo_dis | output | 4 | FIFO disable field per channel |
| ev_done | input | 4 | Done event pulse per channel |
| ev_link | input | 4 | Link-complete event pulse per channel |
| ev_ring | input | 4 | Ring-buffer event pulse per channel |
| ev_lpause | input | 4 | Link-pause event pulse per channel |
| ev_sar | input | 4 | SAR event pulse per channel |
| ev_error | input | 4 | Error event pulse per channel |
| lv_drdy | input | 4 | Device-ready level per channel |
| lv_mrdy | input | 4 | Memory-ready level per channel |
| irq | output | 1 | Combined interrupt request |

## Verification
Several functions can land on a flag in the same clock. A datapath event can meet the software clear of the same flag, or the channel reset. Start can meet abort within one command word. The bench provokes each collision by asserting the event input on the same negative edge that presents the command write. It then reads status to judge the outcome: the event must win over a plain clear, the channel reset must win over any event, and abort must win over start. The bench also checks that a write holding both halves of an enable pair, or both link-pause commands, leaves the state unchanged.

// File: rtl/dcsr_pkg.sv
package dcsr_pkg;
  localparam int DATA_W = 32;

  // command register bit positions
  localparam int CMD_START      = 0;
  localparam int CMD_CONT       = 1;
  localparam int CMD_STOP       = 2;
  localparam int CMD_ABORT      = 3;
  localparam int CMD_FIFO_RST   = 4;
  localparam int CMD_CLR_LINK   = 5;
  localparam int CMD_CLR_RING   = 6;
  localparam int CMD_CLR_DONE   = 7;
  localparam int CMD_CLR_LPAUSE = 8;
  localparam int CMD_SET_LPAUSE = 9;
  localparam int CMD_CHAN_RST   = 31;

  // control register fields
  localparam int CTL_CONT_MODE  = 0;
  localparam int CTL_RING_MODE  = 1;
  localparam int CTL_BURST      = 14;
  localparam int CTL_FIFO_DIS   = 15;
  localparam int CTL_PAIR_BASE  = 16;

  // enable / source indices
  localparam int NUM_IE    = 8;
  localparam int NUM_SRC   = 7;
  localparam int IE_GLOBAL = 7;

  // sticky flag bank indices
  localparam int NUM_FLAG = 5;
  localparam int FL_RING  = 0;
  localparam int FL_LINK  = 1;
  localparam int FL_DONE  = 2;
  localparam int FL_SAR   = 3;
  localparam int FL_ERR   = 4;

  // status register layout
  localparam int ST_BUSY     = 0;
  localparam int ST_ERROR    = 15;
  localparam int ST_SRC_BASE = 17;
  localparam int ST_INT      = 31;

  localparam int REG_CMD  = 0;
  localparam int REG_CTRL = 1;
  localparam int REG_STAT = 2;

  function automatic logic [DATA_W-1:0] spread_odd(input logic [NUM_IE-1:0] v, input int n);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_IE; k++)
      if (k < n) r[ST_SRC_BASE + 2*k] = v[k];
    return r;
  endfunction
endpackage

// File: rtl/dcsr_enables.sv
module dcsr_enables #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_req,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] en
);
  for (genvar k = 0; k < N; k++) begin : g_pair
    always_ff @(posedge clk) begin
      if (rst)                        en[k] <= 1'b0;
      else if (set_req[k] && !clr_req[k]) en[k] <= 1'b1;
      else if (clr_req[k] && !set_req[k]) en[k] <= 1'b0;
    end

    // R3: both halves of a pair written together leave the enable unchanged
    a_r3_pair_both_hold: assert property (@(posedge clk) disable iff (rst)
      (set_req[k] && clr_req[k]) |=> $stable(en[k]));
    // R3: a lone set bit turns the enable on
    a_r3_set_takes: assert property (@(posedge clk) disable iff (rst)
      (set_req[k] && !clr_req[k]) |=> en[k]);
  end
endmodule

// File: rtl/dcsr_flags.sv
module dcsr_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wipe,
  input  logic [N-1:0] set_ev,
  input  logic [N-1:0] clr_cmd,
  output logic [N-1:0] flag
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst || wipe)     flag[i] <= 1'b0;
      else if (set_ev[i])  flag[i] <= 1'b1;
      else if (clr_cmd[i]) flag[i] <= 1'b0;
    end

    // R5: a set flag persists until its clear command or a channel reset
    a_r5_sticky_hold: assert property (@(posedge clk) disable iff (rst)
      (flag[i] && !clr_cmd[i] && !wipe) |=> flag[i]);
    // R6: an event beats a same-cycle clear
    a_r6_event_wins: assert property (@(posedge clk) disable iff (rst)
      (set_ev[i] && !wipe) |=> flag[i]);
    // R9: channel reset empties the flag whatever else happens
    a_r9_wipe_clears: assert property (@(posedge clk) disable iff (rst)
      wipe |=> !flag[i]);
  end
endmodule

// File: rtl/dcsr_channel.sv
module dcsr_channel
  import dcsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              ctrl_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_done,
  input  logic              ev_link,
  input  logic              ev_ring,
  input  logic              ev_lpause,
  input  logic              ev_sar,
  input  logic              ev_error,
  input  logic              lv_drdy,
  input  logic              lv_mrdy,
  output logic              st_start,
  output logic              st_cont,
  output logic              st_stop,
  output logic              st_abort,
  output logic              st_fifo_rst,
  output logic              st_chan_rst,
  output logic              cfg_cont,
  output logic              cfg_ring,
  output logic              cfg_burst,
  output logic              cfg_fifo_dis,
  output logic [DATA_W-1:0] ctrl_rd,
  output logic [DATA_W-1:0] stat_rd,
  output logic              irq_req
);
  logic [DATA_W-1:0] cmd;
  logic [NUM_IE-1:0] ie_set, ie_clr, ie;
  logic [NUM_FLAG-1:0] fl_set, fl_clr, fl;
  logic [NUM_SRC-1:0]  src;
  logic busy, lpause, wipe;
  logic unused_bits;

  assign cmd  = cmd_wr ? wdata : '0;
  assign wipe = cmd[CMD_CHAN_RST];
  assign unused_bits = ^wdata[13:10];

  // strobes toward the datapath, one cycle each
  always_ff @(posedge clk) begin
    if (rst) begin
      st_start <= 1'b0; st_cont <= 1'b0; st_stop <= 1'b0;
      st_abort <= 1'b0; st_fifo_rst <= 1'b0; st_chan_rst <= 1'b0;
    end else begin
      st_start    <= cmd[CMD_START];
      st_cont     <= cmd[CMD_CONT];
      st_stop     <= cmd[CMD_STOP];
      st_abort    <= cmd[CMD_ABORT];
      st_fifo_rst <= cmd[CMD_FIFO_RST];
      st_chan_rst <= cmd[CMD_CHAN_RST];
    end
  end

  // plain control fields
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_cont <= 1'b0; cfg_ring <= 1'b0; cfg_burst <= 1'b0; cfg_fifo_dis <= 1'b0;
    end else if (ctrl_wr) begin
      cfg_cont     <= wdata[CTL_CONT_MODE];
      cfg_ring     <= wdata[CTL_RING_MODE];
      cfg_burst    <= wdata[CTL_BURST];
      cfg_fifo_dis <= wdata[CTL_FIFO_DIS];
    end
  end

  // busy: abort and channel reset beat start, start beats done
  always_ff @(posedge clk) begin
    if (rst)                                   busy <= 1'b0;
    else if (cmd[CMD_ABORT] || wipe)           busy <= 1'b0;
    else if (cmd[CMD_START])                   busy <= 1'b1;
    else if (ev_done)                          busy <= 1'b0;
  end

  // link pause state
  always_ff @(posedge clk) begin
    if (rst || wipe) lpause <= 1'b0;
    else if (ev_lpause) lpause <= 1'b1;
    else if (cmd[CMD_SET_LPAUSE] && !cmd[CMD_CLR_LPAUSE]) lpause <= 1'b1;
    else if (cmd[CMD_CLR_LPAUSE] && !cmd[CMD_SET_LPAUSE]) lpause <= 1'b0;
  end

  always_comb begin
    for (int k = 0; k < NUM_IE; k++) begin
      ie_set[k] = ctrl_wr & wdata[CTL_PAIR_BASE + 2*k + 1];
      ie_clr[k] = ctrl_wr & wdata[CTL_PAIR_BASE + 2*k];
    end
  end

  dcsr_enables #(.N(NUM_IE)) u_ie (
    .clk(clk), .rst(rst), .set_req(ie_set), .clr_req(ie_clr), .en(ie)
  );

  always_comb begin
    fl_set = '0;
    fl_clr = '0;
    fl_set[FL_RING] = ev_ring;  fl_clr[FL_RING] = cmd[CMD_CLR_RING];
    fl_set[FL_LINK] = ev_link;  fl_clr[FL_LINK] = cmd[CMD_CLR_LINK];
    fl_set[FL_DONE] = ev_done;  fl_clr[FL_DONE] = cmd[CMD_CLR_DONE];
    fl_set[FL_SAR]  = ev_sar;
    fl_set[FL_ERR]  = ev_error;
  end

  dcsr_flags #(.N(NUM_FLAG)) u_fl (
    .clk(clk), .rst(rst), .wipe(wipe), .set_ev(fl_set), .clr_cmd(fl_clr), .flag(fl)
  );

  assign src = {lpause, fl[FL_SAR], fl[FL_DONE], lv_mrdy, lv_drdy, fl[FL_LINK], fl[FL_RING]};
  assign irq_req = ie[IE_GLOBAL] & |(src & ie[NUM_SRC-1:0]);

  always_comb begin
    stat_rd = spread_odd({1'b0, src}, NUM_SRC);
    stat_rd[ST_BUSY]  = busy;
    stat_rd[ST_ERROR] = fl[FL_ERR];
    stat_rd[ST_INT]   = irq_req;
  end

  always_comb begin
    ctrl_rd = '0;
    for (int k = 0; k < NUM_IE; k++) ctrl_rd[CTL_PAIR_BASE + 2*k + 1] = ie[k];
    ctrl_rd[CTL_CONT_MODE] = cfg_cont;
    ctrl_rd[CTL_RING_MODE] = cfg_ring;
    ctrl_rd[CTL_BURST]     = cfg_burst;
    ctrl_rd[CTL_FIFO_DIS]  = cfg_fifo_dis;
  end

  // R2: a start strobe only follows a start command write
  a_r2_start_from_write: assert property (@(posedge clk) disable iff (rst)
    st_start |-> $past(cmd_wr && wdata[CMD_START]));
  // R8: abort leaves the channel idle
  a_r8_abort_idles: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[CMD_ABORT]) |=> !stat_rd[ST_BUSY]);
  // R7: both link-pause commands together change nothing
  a_r7_lpause_both_hold: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && wdata[CMD_SET_LPAUSE] && wdata[CMD_CLR_LPAUSE] && !ev_lpause && !wdata[CMD_CHAN_RST])
    |=> $stable(lpause));
endmodule

// File: rtl/dma_chan_csr.sv
module dma_chan_csr
  import dcsr_pkg::*;
#(
  parameter int NUM_CH = 4,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [NUM_CH-1:0] dp_start,
  output logic [NUM_CH-1:0] dp_continue,
  output logic [NUM_CH-1:0] dp_stop,
  output logic [NUM_CH-1:0] dp_abort,
  output logic [NUM_CH-1:0] dp_fifo_rst,
  output logic [NUM_CH-1:0] dp_chan_rst,
  output logic [NUM_CH-1:0] dp_cont_mode,
  output logic [NUM_CH-1:0] dp_ring_mode,
  output logic [NUM_CH-1:0] dp_burst_en,
  output logic [NUM_CH-1:0] dp_fifo_dis,
  input  logic [NUM_CH-1:0] ev_done,
  input  logic [NUM_CH-1:0] ev_link,
  input  logic [NUM_CH-1:0] ev_ring,
  input  logic [NUM_CH-1:0] ev_lpause,
  input  logic [NUM_CH-1:0] ev_sar,
  input  logic [NUM_CH-1:0] ev_error,
  input  logic [NUM_CH-1:0] lv_drdy,
  input  logic [NUM_CH-1:0] lv_mrdy,
  output logic              irq
);
  logic [CH_W-1:0]   ch_sel;
  logic [1:0]        reg_sel;
  logic [DATA_W-1:0] ctrl_rd [NUM_CH];
  logic [DATA_W-1:0] stat_rd [NUM_CH];
  logic [NUM_CH-1:0] chan_irq;
  logic [DATA_W-1:0] rd_mux;

  assign ch_sel  = bus_addr[ADDR_W-1:2];
  assign reg_sel = bus_addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = bus_wr && (ch_sel == CH_W'(c));

    dcsr_channel u_ch (
      .clk(clk), .rst(rst),
      .cmd_wr(hit && reg_sel == 2'(REG_CMD)),
      .ctrl_wr(hit && reg_sel == 2'(REG_CTRL)),
      .wdata(bus_wdata),
      .ev_done(ev_done[c]), .ev_link(ev_link[c]), .ev_ring(ev_ring[c]),
      .ev_lpause(ev_lpause[c]), .ev_sar(ev_sar[c]), .ev_error(ev_error[c]),
      .lv_drdy(lv_drdy[c]), .lv_mrdy(lv_mrdy[c]),
      .st_start(dp_start[c]), .st_cont(dp_continue[c]), .st_stop(dp_stop[c]),
      .st_abort(dp_abort[c]), .st_fifo_rst(dp_fifo_rst[c]), .st_chan_rst(dp_chan_rst[c]),
      .cfg_cont(dp_cont_mode[c]), .cfg_ring(dp_ring_mode[c]),
      .cfg_burst(dp_burst_en[c]), .cfg_fifo_dis(dp_fifo_dis[c]),
      .ctrl_rd(ctrl_rd[c]), .stat_rd(stat_rd[c]), .irq_req(chan_irq[c])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == CH_W'(i)) begin
        case (reg_sel)
          2'(REG_CTRL): rd_mux = ctrl_rd[i];
          2'(REG_STAT): rd_mux = stat_rd[i];
          default:      rd_mux = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq        <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) bus_rdata <= rd_mux;
      irq <= |chan_irq;
    end
  end

  // R10: the output request reflects a channel request one cycle earlier
  a_r10_irq_source: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|chan_irq));
  // R11: read data valid follows a read strobe
  a_r11_rvalid_follows: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);
  // R11: no valid without a preceding read
  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_rd));
endmodule

// File: tb/sim_dma_chan_csr.sv
module sim_dma_chan_csr;
  localparam int NCH = 4;
  localparam int AW  = 4;

  logic clk = 1'b0;
  logic rst;
  logic bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_rvalid;
  logic [NCH-1:0] dp_start, dp_continue, dp_stop, dp_abort, dp_fifo_rst, dp_chan_rst;
  logic [NCH-1:0] dp_cont_mode, dp_ring_mode, dp_burst_en, dp_fifo_dis;
  logic [NCH-1:0] ev_done, ev_link, ev_ring, ev_lpause, ev_sar, ev_error, lv_drdy, lv_mrdy;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rd;

  always #5 clk = ~clk;

  dma_chan_csr #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dp_start(dp_start), .dp_continue(dp_continue), .dp_stop(dp_stop),
    .dp_abort(dp_abort), .dp_fifo_rst(dp_fifo_rst), .dp_chan_rst(dp_chan_rst),
    .dp_cont_mode(dp_cont_mode), .dp_ring_mode(dp_ring_mode),
    .dp_burst_en(dp_burst_en), .dp_fifo_dis(dp_fifo_dis),
    .ev_done(ev_done), .ev_link(ev_link), .ev_ring(ev_ring), .ev_lpause(ev_lpause),
    .ev_sar(ev_sar), .ev_error(ev_error), .lv_drdy(lv_drdy), .lv_mrdy(lv_mrdy),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic set_ev(input int ch, input int kind, input logic v);
    case (kind)
      0: ev_done[ch]   = v;
      1: ev_link[ch]   = v;
      2: ev_ring[ch]   = v;
      3: ev_lpause[ch] = v;
      4: ev_sar[ch]    = v;
      5: ev_error[ch]  = v;
      default: ;
    endcase
  endtask

  // write with an optional event (kind >= 0) in the same cycle
  task automatic wr_ev(input int ch, input int rg, input logic [31:0] d, input int kind);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(ch*4 + rg); bus_wdata = d;
    if (kind >= 0) set_ev(ch, kind, 1'b1);
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
    if (kind >= 0) set_ev(ch, kind, 1'b0);
  endtask

  task automatic wr(input int ch, input int rg, input logic [31:0] d);
    wr_ev(ch, rg, d, -1);
  endtask

  task automatic rd_reg(input int ch, input int rg, output logic [31:0] q);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = AW'(ch*4 + rg);
    @(negedge clk);
    bus_rd = 1'b0;
    q = bus_rdata;
  endtask

  task automatic pulse(input int ch, input int kind);
    @(negedge clk); set_ev(ch, kind, 1'b1);
    @(negedge clk); set_ev(ch, kind, 1'b0);
  endtask

  task automatic clean(input int ch);
    wr(ch, 1, 32'h5555_0000);
    wr(ch, 0, 32'h8000_0000);
  endtask

  task automatic t_reset();
    rd_reg(0, 1, rd); check("R1 ctrl after reset", rd, 32'h0);
    rd_reg(0, 2, rd); check("R1 status after reset", rd, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 strobes after reset", {8'b0, dp_start, dp_abort, dp_chan_rst, dp_burst_en, 8'b0}, 32'h0);
  endtask

  task automatic t_commands();
    wr(1, 0, 32'h1);
    check("R2 start strobe on ch1 only", {28'b0, dp_start}, 32'h2);
    @(negedge clk);
    check("R2 start strobe one cycle", {28'b0, dp_start}, 32'h0);
    wr(1, 0, 32'h16);
    check("R2 cont/stop/fifo strobes", {28'b0, dp_start[1], dp_continue[1], dp_stop[1], dp_fifo_rst[1]}, 32'h7);
    rd_reg(1, 0, rd); check("R2 command reads zero", rd, 32'h0);
    rd_reg(1, 2, rd); check("R8 busy after start", rd, 32'h1);
  endtask

  task automatic t_enables();
    wr(0, 1, 32'h8200_0000);
    rd_reg(0, 1, rd); check("R3 set done+global", rd, 32'h8200_0000);
    wr(0, 1, 32'h0300_0000);
    rd_reg(0, 1, rd); check("R3 both bits unchanged", rd, 32'h8200_0000);
    wr(0, 1, 32'h0100_0000);
    rd_reg(0, 1, rd); check("R3 clear done enable", rd, 32'h8000_0000);
    wr(0, 1, 32'h0);
    rd_reg(0, 1, rd); check("R3 zero write unchanged", rd, 32'h8000_0000);
  endtask

  task automatic t_modes();
    wr(2, 1, 32'h0000_C003);
    check("R4 mode outputs", {28'b0, dp_cont_mode[2], dp_ring_mode[2], dp_burst_en[2], dp_fifo_dis[2]}, 32'hF);
    rd_reg(2, 1, rd); check("R4 mode readback", rd, 32'h0000_C003);
  endtask

  task automatic t_sticky();
    clean(0);
    wr(0, 1, 32'h8200_0000);
    pulse(0, 0);
    rd_reg(0, 2, rd); check("R5 done flag set", rd, 32'h8200_0000);
    check("R10 irq raised", {31'b0, irq}, 32'h1);
    rd_reg(0, 2, rd); check("R5 read does not clear", rd, 32'h8200_0000);
    wr(0, 0, 32'h80);
    rd_reg(0, 2, rd); check("R5 clear-done command", rd, 32'h0);
    check("R10 irq dropped", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_collision();
    clean(0);
    wr_ev(0, 0, 32'h20, 1);
    rd_reg(0, 2, rd); check("R6 event beats clear", rd, 32'h0008_0000);
    wr(0, 0, 32'h20);
    rd_reg(0, 2, rd); check("R5 link clear alone", rd, 32'h0);
  endtask

  task automatic t_lpause();
    clean(1);
    wr(1, 0, 32'h200);
    rd_reg(1, 2, rd); check("R7 set link pause", rd, 32'h2000_0000);
    wr(1, 0, 32'h300);
    rd_reg(1, 2, rd); check("R7 both commands unchanged", rd, 32'h2000_0000);
    wr(1, 0, 32'h100);
    rd_reg(1, 2, rd); check("R7 clear link pause", rd, 32'h0);
  endtask

  task automatic t_busy();
    wr(3, 0, 32'h1);
    rd_reg(3, 2, rd); check("R8 busy set", rd, 32'h1);
    pulse(3, 0);
    rd_reg(3, 2, rd); check("R8 done clears busy", rd, 32'h0200_0000);
    wr(3, 0, 32'h9);
    check("R8 abort strobe", {31'b0, dp_abort[3]}, 32'h1);
    rd_reg(3, 2, rd); check("R8 abort beats start", rd, 32'h0200_0000);
  endtask

  task automatic t_chanrst();
    clean(0);
    wr(0, 1, 32'h8800_0000);
    pulse(0, 4);
    pulse(0, 5);
    wr(0, 0, 32'h200);
    rd_reg(0, 2, rd); check("R9 flags before reset", rd, 32'hA800_8000);
    wr_ev(0, 0, 32'h8000_0000, 0);
    check("R9 channel reset strobe", {28'b0, dp_chan_rst}, 32'h1);
    rd_reg(0, 2, rd); check("R9 reset wipes flags", rd, 32'h0);
    rd_reg(0, 1, rd); check("R9 enables kept", rd, 32'h8800_0000);
  endtask

  task automatic t_levels();
    clean(2);
    wr(2, 1, 32'h8020_0000);
    @(negedge clk); lv_drdy[2] = 1'b1;
    rd_reg(2, 2, rd); check("R12 drdy level shown", rd, 32'h8020_0000);
    check("R10 irq from level", {31'b0, irq}, 32'h1);
    lv_drdy[2] = 1'b0;
    rd_reg(2, 2, rd); check("R12 drdy not sticky", rd, 32'h0);
    check("R10 irq gone", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_addr();
    clean(0);
    wr(1, 1, 32'h8000_0000);
    rd_reg(0, 1, rd); check("R11 write isolated to channel", rd, 32'h0);
    rd_reg(1, 1, rd); check("R11 addressed channel written", rd, 32'h8000_0000);
    @(negedge clk); bus_rd = 1'b1; bus_addr = AW'(1*4 + 3);
    @(negedge clk); bus_rd = 1'b0;
    check("R11 rvalid after read", {31'b0, bus_rvalid}, 32'h1);
    check("R11 register 3 reads zero", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    ev_done = '0; ev_link = '0; ev_ring = '0; ev_lpause = '0; ev_sar = '0; ev_error = '0;
    lv_drdy = '0; lv_mrdy = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_commands();
    t_enables();
    t_modes();
    t_sticky();
    t_collision();
    t_lpause();
    t_busy();
    t_chanrst();
    t_levels();
    t_addr();
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule